// File: doc/BRIEF.md
# Reorder Buffer Vulnerability Throttle

This block keeps a per-cycle count of the soft-error-vulnerable bits held in a reorder buffer and holds back instruction dispatch so that the count never passes a programmable limit. The buffer itself, the instruction payload and any redundant-execution logic live elsewhere. The block only receives event strobes with entry indices and answers with a stall signal and the current count.

Each entry is charged in two phases. When an instruction is dispatched, its base field becomes vulnerable. When the result is written back later, the result field becomes vulnerable too. Writeback cannot be refused, so every admission reserves room for the result that is still to come. A commit releases whatever its entry holds, and so does a squash, because the squashed state is no longer needed. A whole-entry mode reports every occupied entry at full width. In that mode the limit becomes a plain occupancy cap, computed from the bound.

Top module: `rob_vuln_throttle`

## Requirements
- R1: While reset is asserted and after it is released, `ace_count` is 0, every entry is free and, provided `vuln_bound` is at least BASE_BITS+RESULT_BITS, `disp_stall` is 0.
- R2: A dispatch is accepted when `disp_valid` is 1, `disp_stall` is 0 and entry `disp_idx` is free or is being released in the same cycle. It adds BASE_BITS (default 40) to the count. A dispatch to an occupied entry has no effect.
- R3: A writeback to an occupied entry whose result is not yet written adds RESULT_BITS (default 24). A writeback to a free entry, to an entry already written, or to an entry released in the same cycle has no effect.
- R4: `commit_valid` with the binary index `commit_idx` releases that entry. Bit i of `squash_mask` releases entry i. A released entry gives back 40 bits if its result is unwritten and 64 bits if it is written, and an entry named by both inputs gives back its bits once.
- R5: Dispatch, writeback, commit and squash in one cycle are summed into a single update. `ace_count` shows the new value one clock edge later, and it holds when no event occurs.
- R6: `disp_stall` is combinational in the same cycle. Let k be the number of entries that remain occupied after this cycle's commit and squash. `disp_stall` is 1 exactly when (k+1)*(BASE_BITS+RESULT_BITS) > `vuln_bound`. A dispatch request is ignored while it is 1.
- R7: When `vuln_bound` is below BASE_BITS+RESULT_BITS, `disp_stall` stays 1.
- R8: With `whole_entry_mode` = 1, `ace_count` reads occupancy*(BASE_BITS+RESULT_BITS), so a writeback leaves it unchanged. The stall is decided as occupancy-after-release >= floor(`vuln_bound`/(BASE_BITS+RESULT_BITS)), which gives the same decisions as R6.
- R9: While `vuln_bound` is held constant, `ace_count` never exceeds it. The bound and the mode are changed only while the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| disp_valid | input | 1 | Dispatch request |
| disp_idx | input | IDX_W | Entry index for dispatch |
| wb_valid | input | 1 | Result writeback strobe |
| wb_idx | input | IDX_W | Entry index for writeback |
| commit_valid | input | 1 | Commit strobe |
| commit_idx | input | IDX_W | Entry index for commit |
| squash_mask | input | ENTRIES | One bit per entry to discard |
| vuln_bound | input | CNT_W | Limit on vulnerable bits |
| whole_entry_mode | input | 1 | 1: full-width charge at dispatch |
| disp_stall | output | 1 | Dispatch must wait |
| ace_count | output | CNT_W | Current vulnerable-bit count |

## Verification
`disp_stall` is due in the same cycle as the strobes that shape it. The bench drives the inputs at the falling edge and samples the stall one nanosecond later, well before the next rising edge. `ace_count` is due one rising edge after the events, so the bench samples it at the following falling edge, before it drives the next stimulus. A vector table covers a full fill, stall, overlap and squash sequence. Directed steps cover reset, whole-entry mode and a tiny bound. A long random phase is then compared cycle by cycle with an occupancy-based model.

// File: rtl/rob_vt_pkg.sv
package rob_vt_pkg;
  typedef enum logic {
    MODE_EXACT = 1'b0,
    MODE_WHOLE = 1'b1
  } charge_mode_e;
endpackage

// File: rtl/rob_vt_flags.sv
module rob_vt_flags #(
  parameter int ENTRIES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] set_vec,
  input  logic [ENTRIES-1:0] clr_vec,
  input  logic [ENTRIES-1:0] fill_vec,
  output logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] filled
);
  logic [ENTRIES-1:0] busy_nx, filled_nx;
  logic               upd_en;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_comb begin
      busy_nx[e]   = set_vec[e] | (busy[e] & ~clr_vec[e]);
      filled_nx[e] = ~set_vec[e] & ~clr_vec[e] & (filled[e] | fill_vec[e]);
    end
  end

  assign upd_en = |{set_vec, clr_vec, fill_vec};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= '0;
      filled <= '0;
    end else if (upd_en) begin
      busy   <= busy_nx;
      filled <= filled_nx;
    end
  end
endmodule

// File: rtl/rob_vt_release.sv
module rob_vt_release #(
  parameter int ENTRIES     = 16,
  parameter int BASE_BITS   = 40,
  parameter int RESULT_BITS = 24,
  parameter int CNT_W       = 11,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int OCC_W      = $clog2(ENTRIES + 1),
  localparam int TOT        = BASE_BITS + RESULT_BITS
) (
  input  logic [ENTRIES-1:0] busy,
  input  logic [ENTRIES-1:0] filled,
  input  logic               commit_valid,
  input  logic [IDX_W-1:0]   commit_idx,
  input  logic [ENTRIES-1:0] squash_mask,
  output logic [ENTRIES-1:0] clr_vec,
  output logic [CNT_W-1:0]   rel_bits,
  output logic [OCC_W-1:0]   occ_now,
  output logic [OCC_W-1:0]   occ_post,
  output logic [OCC_W-1:0]   pend_post
);
  logic [ENTRIES-1:0] commit_hot;

  always_comb begin
    commit_hot = '0;
    if (commit_valid) commit_hot[commit_idx] = 1'b1;
    clr_vec = (commit_hot | squash_mask) & busy;
  end

  always_comb begin
    rel_bits  = '0;
    occ_now   = '0;
    occ_post  = '0;
    pend_post = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (clr_vec[e])
        rel_bits = rel_bits + (filled[e] ? CNT_W'(TOT) : CNT_W'(BASE_BITS));
      if (busy[e]) occ_now = occ_now + OCC_W'(1);
      if (busy[e] && !clr_vec[e]) occ_post = occ_post + OCC_W'(1);
      if (busy[e] && !clr_vec[e] && !filled[e]) pend_post = pend_post + OCC_W'(1);
    end
  end
endmodule

// File: rtl/rob_vt_gate.sv
module rob_vt_gate
  import rob_vt_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int BASE_BITS   = 40,
  parameter int RESULT_BITS = 24,
  parameter int CNT_W       = 11,
  localparam int OCC_W      = $clog2(ENTRIES + 1),
  localparam int TOT        = BASE_BITS + RESULT_BITS,
  localparam int SUM_W      = CNT_W + 2
) (
  input  logic [CNT_W-1:0] exact_post,
  input  logic [OCC_W-1:0] occ_post,
  input  logic [OCC_W-1:0] pend_post,
  input  logic [CNT_W-1:0] bound,
  input  charge_mode_e     mode,
  output logic             stall
);
  logic [SUM_W-1:0] need;
  logic [CNT_W-1:0] cap;
  logic             over, cap_hit;

  always_comb begin
    // exact path: present bits + reserve for pending results + one whole entry
    need    = SUM_W'(exact_post) + SUM_W'(pend_post) * SUM_W'(RESULT_BITS) + SUM_W'(TOT);
    over    = need > SUM_W'(bound);
    // whole-entry path: occupancy cap derived from the bound
    cap     = bound / CNT_W'(TOT);
    cap_hit = CNT_W'(occ_post) >= cap;
    stall   = (mode == MODE_WHOLE) ? cap_hit : over;
  end
endmodule

// File: rtl/rob_vuln_throttle.sv
module rob_vuln_throttle
  import rob_vt_pkg::*;
#(
  parameter int ENTRIES     = 16,
  parameter int BASE_BITS   = 40,
  parameter int RESULT_BITS = 24,
  localparam int IDX_W      = $clog2(ENTRIES),
  localparam int TOT        = BASE_BITS + RESULT_BITS,
  localparam int CNT_W      = $clog2(ENTRIES * TOT + 1),
  localparam int OCC_W      = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               disp_valid,
  input  logic [IDX_W-1:0]   disp_idx,
  input  logic               wb_valid,
  input  logic [IDX_W-1:0]   wb_idx,
  input  logic               commit_valid,
  input  logic [IDX_W-1:0]   commit_idx,
  input  logic [ENTRIES-1:0] squash_mask,
  input  logic [CNT_W-1:0]   vuln_bound,
  input  logic               whole_entry_mode,
  output logic               disp_stall,
  output logic [CNT_W-1:0]   ace_count
);
  logic [1:0]         rst_pipe;
  logic               srst_n;
  logic [ENTRIES-1:0] busy, filled, clr_vec, set_vec, fill_vec;
  logic [CNT_W-1:0]   exact_q, exact_nx, exact_post, rel_bits;
  logic [OCC_W-1:0]   occ_now, occ_post, pend_post;
  logic               accept, exact_en, stall;
  charge_mode_e       mode;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  assign mode = charge_mode_e'(whole_entry_mode);

  rob_vt_flags #(.ENTRIES(ENTRIES)) u_flags (
    .clk      (clk),
    .rst_n    (srst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .fill_vec (fill_vec),
    .busy     (busy),
    .filled   (filled)
  );

  rob_vt_release #(
    .ENTRIES(ENTRIES), .BASE_BITS(BASE_BITS), .RESULT_BITS(RESULT_BITS), .CNT_W(CNT_W)
  ) u_rel (
    .busy         (busy),
    .filled       (filled),
    .commit_valid (commit_valid),
    .commit_idx   (commit_idx),
    .squash_mask  (squash_mask),
    .clr_vec      (clr_vec),
    .rel_bits     (rel_bits),
    .occ_now      (occ_now),
    .occ_post     (occ_post),
    .pend_post    (pend_post)
  );

  assign exact_post = exact_q - rel_bits;

  rob_vt_gate #(
    .ENTRIES(ENTRIES), .BASE_BITS(BASE_BITS), .RESULT_BITS(RESULT_BITS), .CNT_W(CNT_W)
  ) u_gate (
    .exact_post (exact_post),
    .occ_post   (occ_post),
    .pend_post  (pend_post),
    .bound      (vuln_bound),
    .mode       (mode),
    .stall      (stall)
  );

  // next-state for events of this cycle
  always_comb begin
    set_vec  = '0;
    fill_vec = '0;
    accept   = disp_valid & ~stall & ~(busy[disp_idx] & ~clr_vec[disp_idx]);
    if (accept) set_vec[disp_idx] = 1'b1;
    if (wb_valid)
      fill_vec[wb_idx] = busy[wb_idx] & ~filled[wb_idx] & ~clr_vec[wb_idx];
    exact_nx = exact_post
             + (accept      ? CNT_W'(BASE_BITS)   : '0)
             + ((|fill_vec) ? CNT_W'(RESULT_BITS) : '0);
    exact_en = accept | (|fill_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       exact_q <= '0;
    else if (exact_en) exact_q <= exact_nx;
  end

  assign disp_stall = stall;
  assign ace_count  = (mode == MODE_WHOLE) ? CNT_W'(occ_now) * CNT_W'(TOT) : exact_q;
endmodule

// File: rtl/rob_vt_checker.sv
module rob_vt_checker #(
  parameter int ENTRIES     = 16,
  parameter int BASE_BITS   = 40,
  parameter int RESULT_BITS = 24,
  localparam int TOT        = BASE_BITS + RESULT_BITS,
  localparam int CNT_W      = $clog2(ENTRIES * TOT + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_valid,
  input logic               wb_valid,
  input logic               commit_valid,
  input logic [ENTRIES-1:0] squash_mask,
  input logic [CNT_W-1:0]   vuln_bound,
  input logic               whole_entry_mode,
  input logic               disp_stall,
  input logic [CNT_W-1:0]   ace_count
);
  a_r7_small_bound_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (vuln_bound < CNT_W'(TOT)) |-> disp_stall);

  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_valid && !wb_valid && !commit_valid && squash_mask == '0)
    |=> ($stable(ace_count) || $changed(whole_entry_mode)));

  a_r4_release_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
    (!disp_valid && !wb_valid && (commit_valid || squash_mask != '0))
    |=> (ace_count <= $past(ace_count) || $changed(whole_entry_mode)));

  a_r9_within_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_stall && $stable(vuln_bound))
    |=> (ace_count <= $past(vuln_bound)));
endmodule

bind rob_vuln_throttle rob_vt_checker #(
  .ENTRIES(ENTRIES), .BASE_BITS(BASE_BITS), .RESULT_BITS(RESULT_BITS)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .disp_valid       (disp_valid),
  .wb_valid         (wb_valid),
  .commit_valid     (commit_valid),
  .squash_mask      (squash_mask),
  .vuln_bound       (vuln_bound),
  .whole_entry_mode (whole_entry_mode),
  .disp_stall       (disp_stall),
  .ace_count        (ace_count)
);

// File: tb/rob_vuln_throttle_test.sv
`timescale 1ns/1ps
module rob_vuln_throttle_test;
  localparam int N = 16, IW = 4, B = 40, R = 24, TOT = 64, CW = 11, ROWS = 14;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, dv, wv, cv, mode, stall;
  logic [IW-1:0] di, wi, ci;
  logic [N-1:0]  sq;
  logic [CW-1:0] bound, cnt;

  rob_vuln_throttle uut (
    .clk(clk), .rst_n(rst_n), .disp_valid(dv), .disp_idx(di), .wb_valid(wv), .wb_idx(wi),
    .commit_valid(cv), .commit_idx(ci), .squash_mask(sq), .vuln_bound(bound),
    .whole_entry_mode(mode), .disp_stall(stall), .ace_count(cnt)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [N-1:0] m_busy, m_done;
  int m_exact;

  // row: dv, di, wv, wi, cv, ci, squash, expected stall, expected count (bound 256)
  localparam logic [42:0] VEC [ROWS] = '{
    {1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd40},
    {1'b1, 4'd1, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd80},
    {1'b1, 4'd2, 1'b1, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd144},
    {1'b1, 4'd3, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd184},
    {1'b1, 4'd4, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b1, 11'd184},
    {1'b1, 4'd4, 1'b0, 4'd0, 1'b1, 4'd0, 16'h0000, 1'b0, 11'd160},
    {1'b0, 4'd0, 1'b1, 4'd1, 1'b0, 4'd0, 16'h0000, 1'b1, 11'd184},
    {1'b0, 4'd0, 1'b1, 4'd1, 1'b0, 4'd0, 16'h0000, 1'b1, 11'd184},
    {1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h000C, 1'b0, 11'd104},
    {1'b0, 4'd0, 1'b1, 4'd4, 1'b1, 4'd1, 16'h0000, 1'b0, 11'd64},
    {1'b1, 4'd5, 1'b1, 4'd5, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd104},
    {1'b1, 4'd5, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd104},
    {1'b0, 4'd0, 1'b0, 4'd0, 1'b1, 4'd4, 16'h0030, 1'b0, 11'd0},
    {1'b0, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0, 16'h0000, 1'b0, 11'd0}
  };
  string row_req [ROWS] = '{"R2", "R2", "R3", "R6", "R6", "R5", "R3",
                            "R3", "R4", "R5", "R3", "R2", "R4", "R5"};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(bit d, int dx, bit w, int wx, bit c, int cx, logic [N-1:0] s);
    dv = d; di = IW'(dx); wv = w; wi = IW'(wx); cv = c; ci = IW'(cx); sq = s;
  endtask

  // called at a falling edge with inputs driven; model follows the requirements
  task automatic step(string req, bit use_exp, bit es, int ec);
    logic [N-1:0] clr;
    int occ, exp_stall, exp_cnt;
    bit acc, wok;
    clr = sq & m_busy;
    if (cv) clr[ci] = clr[ci] | m_busy[ci];
    occ = $countones(m_busy & ~clr);
    exp_stall = ((occ + 1) * TOT > int'(bound)) ? 1 : 0;
    #1;
    check({req, " stall"}, int'(stall), use_exp ? int'(es) : exp_stall);
    acc = dv && (exp_stall == 0) && !(m_busy[di] && !clr[di]);
    wok = wv && m_busy[wi] && !m_done[wi] && !clr[wi];
    @(posedge clk);
    for (int e = 0; e < N; e++)
      if (clr[e]) m_exact -= m_done[e] ? TOT : B;
    m_busy &= ~clr;
    m_done &= ~clr;
    if (wok) begin m_done[wi] = 1'b1; m_exact += R; end
    if (acc) begin m_busy[di] = 1'b1; m_done[di] = 1'b0; m_exact += B; end
    @(negedge clk);
    exp_cnt = mode ? $countones(m_busy) * TOT : m_exact;
    check({req, " count"}, int'(cnt), use_exp ? ec : exp_cnt);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode = 1'b0; bound = 11'd256;
    drive(0, 0, 0, 0, 0, 0, '0);
    m_busy = '0; m_done = '0; m_exact = 0;
    repeat (3) @(negedge clk);
    check("R1 stall in reset", int'(stall), 0);
    check("R1 count in reset", int'(cnt), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 stall after reset", int'(stall), 0);
    check("R1 count after reset", int'(cnt), 0);

    // vector table, exact mode, bound 256 = four whole entries
    for (int r = 0; r < ROWS; r++) begin
      drive(VEC[r][42], int'(VEC[r][41:38]), VEC[r][37], int'(VEC[r][36:33]),
            VEC[r][32], int'(VEC[r][31:28]), VEC[r][27:12]);
      step(row_req[r], 1, VEC[r][11], int'(VEC[r][10:0]));
    end

    // whole-entry mode, bound 200 -> cap of three entries
    mode = 1'b1; bound = 11'd200;
    drive(1, 0, 0, 0, 0, 0, '0); step("R8 whole disp0", 1, 0, 64);
    drive(1, 1, 0, 0, 0, 0, '0); step("R8 whole disp1", 1, 0, 128);
    drive(0, 0, 1, 0, 0, 0, '0); step("R8 whole writeback", 1, 0, 128);
    drive(1, 2, 0, 0, 0, 0, '0); step("R8 whole disp2", 1, 0, 192);
    drive(1, 3, 0, 0, 0, 0, '0); step("R8 whole cap stall", 1, 1, 192);
    drive(0, 0, 0, 0, 0, 0, 16'hFFFF); step("R4 squash all", 1, 0, 0);

    // bound smaller than one entry
    mode = 1'b0; bound = 11'd40;
    drive(1, 0, 0, 0, 0, 0, '0); step("R7 tiny bound", 1, 1, 0);
    drive(0, 0, 0, 0, 0, 0, '0); step("R7 tiny bound idle", 1, 1, 0);

    // random traffic against the model, bound constant
    bound = 11'd640;
    for (int k = 0; k < 3000; k++) begin
      drive(bit'($urandom % 2), int'($urandom % N), bit'($urandom % 2), int'($urandom % N),
            bit'($urandom % 3 == 0), int'($urandom % N),
            ($urandom % 20 == 0) ? N'($urandom) : '0);
      step("R6 random", 0, 0, 0);
      check("R9 count within bound", int'(cnt <= bound), 1);
    end
    drive(0, 0, 0, 0, 0, 0, '0);
    finish_run();
  end
endmodule